// File: doc/BRIEF.md
# Target-Side Bus Phase and Byte Sequencer

This block drives the three bus-phase lines (message, control/data, direction) from the target side of a parallel SCSI bus. It also hands single bytes to a byte-transfer engine through a programmed-I/O handshake. A phase change waits until the initiator has released ACK. The block then drives all three phase lines in one step and holds off completion for a settle time before it reports done. When the direction line turns from initiator-driven to target-driven, the settle time is doubled, which covers the data-release delay.

A byte send works as follows. The block enables the transfer engine, waits until the engine is ready, and writes the byte. It then waits for the engine to be ready again and disables it. Only one operation runs at a time. A request raised while the block is busy is served once the block returns to idle.

Top module: `tgt_phase_seq`

## Requirements
- R1: While reset is held, and before the first request, `phase_o` is 3'b000 and `busy_o`, `done_o`, `pio_en_o` and `pio_wr_o` are all 0.
- R2: `phase_o` (bit 2 message, bit 1 control/data, bit 0 direction, 1 meaning target drives) does not change while `ack_i` is sampled high. The first clock edge of a phase operation at which `ack_i` is sampled low loads all three bits from the requested value at once.
- R3: When the direction bit does not go from 0 to 1 (same value, or 1 to 0), `done_o` rises SETTLE cycles (default 4) after the edge that updated `phase_o`.
- R4: When the direction bit goes from 0 to 1, `done_o` rises 2*SETTLE cycles after the edge that updated `phase_o`.
- R5: `done_o` is a single-cycle pulse. `busy_o` is high from the edge that accepts a request through the done cycle, and low in the cycle that follows.
- R6: A byte send raises `pio_en_o`. It then gives exactly one single-cycle `pio_wr_o` pulse, only after `pio_rdy_i` was sampled high while enabled, and `pio_data_o` carries the requested byte during that pulse.
- R7: After the write, the block waits for `pio_rdy_i` again. At the first edge that samples it high, `pio_en_o` falls and `done_o` rises together.
- R8: When phase and send requests are both high in an idle cycle, the phase change is served first. The send is served after it completes.
- R9: A request raised while another operation runs has no effect until the block is idle: `phase_o` stays stable throughout a send, and `pio_en_o` stays low throughout a phase change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| phase_req_i | input | 1 | Phase-change request, held until `busy_o` is seen |
| phase_val_i | input | 3 | Requested phase: [2] message, [1] control/data, [0] direction |
| send_req_i | input | 1 | Byte-send request, held until `busy_o` is seen |
| send_byte_i | input | 8 | Byte to send |
| ack_i | input | 1 | Sampled ACK from the initiator |
| pio_rdy_i | input | 1 | Transfer engine ready |
| phase_o | output | 3 | Driven phase lines |
| pio_en_o | output | 1 | Transfer engine enable |
| pio_wr_o | output | 1 | One-cycle byte write strobe |
| pio_data_o | output | 8 | Byte presented with the write strobe |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | One-cycle completion pulse |

## Verification
A phase request and a byte-send request can arrive in the same idle cycle. The bench raises both together, and it also raises each one while the other operation is in progress. For these cases it checks two things: that the enable stays low for the whole phase settle window, and that the phase lines do not move during a send. It then checks that the held request is served in full afterwards, with its own timing and byte intact. Random mixes of phase values, ACK hold times and engine ready latencies cover every direction transition against settle windows that the bench computes itself.

// File: rtl/tps_pkg.sv
package tps_pkg;
  typedef enum logic [1:0] {MODE_IDLE, MODE_PHASE, MODE_SEND} mode_e;
  typedef enum logic [1:0] {PH_IDLE, PH_ACK, PH_SETTLE} ph_state_e;
  typedef enum logic [1:0] {TX_IDLE, TX_RDY1, TX_WR, TX_RDY2} tx_state_e;
  localparam int PHASE_W = 3;
  localparam int DIR_BIT = 0;
endpackage

// File: rtl/tps_settle_timer.sv
module tps_settle_timer #(
  parameter int SETTLE = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic load_i,
  input  logic double_i,
  output logic expired_o
);
  localparam int MAXC = 2 * SETTLE;
  localparam int CW   = $clog2(MAXC + 1);
  localparam logic [CW-1:0] LD_ONE = CW'(SETTLE - 1);
  localparam logic [CW-1:0] LD_TWO = CW'(MAXC - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            cnt_q <= '0;
    else if (load_i)        cnt_q <= double_i ? LD_TWO : LD_ONE;
    else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
  end

  assign expired_o = (cnt_q == '0);
endmodule

// File: rtl/tps_phase_unit.sv
module tps_phase_unit
  import tps_pkg::*;
#(
  parameter int SETTLE = 4
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               start_i,
  input  logic [PHASE_W-1:0] val_i,
  input  logic               ack_i,
  output logic [PHASE_W-1:0] phase_o,
  output logic               fin_o
);
  ph_state_e          st_q;
  logic [PHASE_W-1:0] tgt_q;
  logic [PHASE_W-1:0] phase_q;
  logic               fin_q;
  logic               drive;
  logic               turn_in;
  logic               expired;

  assign drive   = (st_q == PH_ACK) && !ack_i;
  // out-to-in reversal needs the data-release delay on top of settle
  assign turn_in = !phase_q[DIR_BIT] && tgt_q[DIR_BIT];

  tps_settle_timer #(.SETTLE(SETTLE)) u_timer (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .load_i    (drive),
    .double_i  (turn_in),
    .expired_o (expired)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= PH_IDLE;
      tgt_q   <= '0;
      phase_q <= '0;
      fin_q   <= 1'b0;
    end else begin
      fin_q <= 1'b0;
      unique case (st_q)
        PH_IDLE: if (start_i) begin
          tgt_q <= val_i;
          st_q  <= PH_ACK;
        end
        PH_ACK: if (drive) begin
          phase_q <= tgt_q;
          st_q    <= PH_SETTLE;
        end
        PH_SETTLE: if (expired) begin
          fin_q <= 1'b1;
          st_q  <= PH_IDLE;
        end
        default: st_q <= PH_IDLE;
      endcase
    end
  end

  assign phase_o = phase_q;
  assign fin_o   = fin_q;
endmodule

// File: rtl/tps_pio_unit.sv
module tps_pio_unit
  import tps_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [DATA_W-1:0] byte_i,
  input  logic              rdy_i,
  output logic              en_o,
  output logic              wr_o,
  output logic [DATA_W-1:0] data_o,
  output logic              fin_o
);
  tx_state_e         st_q;
  logic              en_q;
  logic              wr_q;
  logic              fin_q;
  logic [DATA_W-1:0] data_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= TX_IDLE;
      en_q   <= 1'b0;
      wr_q   <= 1'b0;
      fin_q  <= 1'b0;
      data_q <= '0;
    end else begin
      fin_q <= 1'b0;
      wr_q  <= 1'b0;
      unique case (st_q)
        TX_IDLE: if (start_i) begin
          en_q   <= 1'b1;
          data_q <= byte_i;
          st_q   <= TX_RDY1;
        end
        TX_RDY1: if (rdy_i) begin
          wr_q <= 1'b1;
          st_q <= TX_WR;
        end
        // strobe cycle: ready from before the write must not count
        TX_WR: st_q <= TX_RDY2;
        TX_RDY2: if (rdy_i) begin
          en_q  <= 1'b0;
          fin_q <= 1'b1;
          st_q  <= TX_IDLE;
        end
        default: st_q <= TX_IDLE;
      endcase
    end
  end

  assign en_o   = en_q;
  assign wr_o   = wr_q;
  assign data_o = data_q;
  assign fin_o  = fin_q;
endmodule

// File: rtl/tgt_phase_seq.sv
module tgt_phase_seq
  import tps_pkg::*;
#(
  parameter int SETTLE = 4,
  parameter int DATA_W = 8
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               phase_req_i,
  input  logic [PHASE_W-1:0] phase_val_i,
  input  logic               send_req_i,
  input  logic [DATA_W-1:0]  send_byte_i,
  input  logic               ack_i,
  input  logic               pio_rdy_i,
  output logic [PHASE_W-1:0] phase_o,
  output logic               pio_en_o,
  output logic               pio_wr_o,
  output logic [DATA_W-1:0]  pio_data_o,
  output logic               busy_o,
  output logic               done_o
);
  mode_e mode_q;
  logic  idle;
  logic  start_ph;
  logic  start_tx;
  logic  ph_fin;
  logic  tx_fin;

  assign idle     = (mode_q == MODE_IDLE);
  // phase change wins a same-cycle tie
  assign start_ph = idle && phase_req_i;
  assign start_tx = idle && !phase_req_i && send_req_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)               mode_q <= MODE_IDLE;
    else if (start_ph)         mode_q <= MODE_PHASE;
    else if (start_tx)         mode_q <= MODE_SEND;
    else if (ph_fin || tx_fin) mode_q <= MODE_IDLE;
  end

  tps_phase_unit #(.SETTLE(SETTLE)) u_phase (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (start_ph),
    .val_i   (phase_val_i),
    .ack_i   (ack_i),
    .phase_o (phase_o),
    .fin_o   (ph_fin)
  );

  tps_pio_unit #(.DATA_W(DATA_W)) u_pio (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (start_tx),
    .byte_i  (send_byte_i),
    .rdy_i   (pio_rdy_i),
    .en_o    (pio_en_o),
    .wr_o    (pio_wr_o),
    .data_o  (pio_data_o),
    .fin_o   (tx_fin)
  );

  assign busy_o = !idle;
  assign done_o = ph_fin || tx_fin;
endmodule

// File: rtl/tps_checker.sv
module tps_checker (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       phase_req_i,
  input logic [2:0] phase_val_i,
  input logic       send_req_i,
  input logic [7:0] send_byte_i,
  input logic       ack_i,
  input logic       pio_rdy_i,
  input logic [2:0] phase_o,
  input logic       pio_en_o,
  input logic       pio_wr_o,
  input logic [7:0] pio_data_o,
  input logic       busy_o,
  input logic       done_o
);
  assert_ack_guard_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(phase_o) |-> !$past(ack_i));

  assert_done_pulse_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  assert_busy_at_done_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> busy_o);

  assert_wr_enabled_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pio_wr_o |-> pio_en_o);

  assert_wr_after_rdy_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(pio_wr_o) |-> $past(pio_rdy_i));

  assert_wr_single_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pio_wr_o |=> !pio_wr_o);

  assert_en_off_done_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(pio_en_o) |-> done_o);

  assert_phase_quiet_send_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pio_en_o |-> $stable(phase_o));
endmodule

bind tgt_phase_seq tps_checker u_chk (.*);

// File: tb/tgt_phase_seq_test.sv
module tgt_phase_seq_test;
  localparam int D = 4;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       phase_req_i = 1'b0;
  logic [2:0] phase_val_i = '0;
  logic       send_req_i = 1'b0;
  logic [7:0] send_byte_i = '0;
  logic       ack_i = 1'b0;
  logic       pio_rdy_i = 1'b0;
  logic [2:0] phase_o;
  logic       pio_en_o, pio_wr_o, busy_o, done_o;
  logic [7:0] pio_data_o;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  logic [2:0] cur = '0;

  // engine model state
  int   wr_cnt = 0;
  int   rdy2_cyc = -1;
  int   cd = 0;
  logic en_prev = 1'b0;
  logic [7:0] cap = '0;

  tgt_phase_seq uut (.*);

  always #2 clk_i = ~clk_i;
  always @(posedge clk_i) cyc <= cyc + 1;

  // byte engine model: ready drops on each write and returns after a random wait
  always @(negedge clk_i) begin
    if (pio_en_o && !en_prev) begin
      wr_cnt = 0;
      rdy2_cyc = -1;
    end
    if (!pio_en_o) begin
      pio_rdy_i = 1'b0;
      cd = int'($urandom_range(0, 3));
    end else if (pio_wr_o) begin
      wr_cnt++;
      cap = pio_data_o;
      pio_rdy_i = 1'b0;
      cd = int'($urandom_range(0, 3));
    end else if (cd > 0) begin
      cd--;
    end else begin
      if (!pio_rdy_i && wr_cnt > 0) rdy2_cyc = cyc;
      pio_rdy_i = 1'b1;
    end
    en_prev = pio_en_o;
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic int settle_len(input logic [2:0] from, input logic [2:0] to);
    return (!from[0] && to[0]) ? 2 * D : D;
  endfunction

  task automatic wait_busy();
    int n = 0;
    do begin @(negedge clk_i); n++; end while (!busy_o && n < 50);
    chk(busy_o, "R5", "busy after request", int'(busy_o), 1);
  endtask

  task automatic phase_track(input logic [2:0] nv, input int c_rel, input bit excl);
    int exp_n = settle_len(cur, nv);
    int tp = -1;
    int td = -1;
    for (int k = 0; k < 3 * D + 20; k++) begin
      @(negedge clk_i);
      if (excl && pio_en_o) chk(0, "R9", "enable during phase change", 1, 0);
      if (tp < 0 && phase_o != cur) tp = cyc;
      if (done_o) begin td = cyc; break; end
    end
    chk(phase_o == nv, "R2", "phase value", int'(phase_o), int'(nv));
    if (nv != cur) chk(tp == c_rel + 1, "R2", "phase drive cycle", tp, c_rel + 1);
    if (!cur[0] && nv[0])
      chk(td == c_rel + 1 + exp_n, "R4", "done cycle after reversal", td, c_rel + 1 + exp_n);
    else
      chk(td == c_rel + 1 + exp_n, "R3", "done cycle", td, c_rel + 1 + exp_n);
    chk(busy_o, "R5", "busy in done cycle", int'(busy_o), 1);
    @(negedge clk_i);
    chk(!done_o && !busy_o, "R5", "done/busy after pulse", int'({done_o, busy_o}), 0);
    cur = nv;
  endtask

  task automatic do_phase(input logic [2:0] nv, input int hold);
    int c_rel;
    ack_i = (hold > 0);
    phase_val_i = nv;
    phase_req_i = 1'b1;
    wait_busy();
    phase_req_i = 1'b0;
    for (int k = 0; k < hold; k++) begin
      @(negedge clk_i);
      chk(phase_o == cur, "R2", "phase held under ack", int'(phase_o), int'(cur));
    end
    ack_i = 1'b0;
    c_rel = cyc;
    phase_track(nv, c_rel, 1'b0);
  endtask

  task automatic send_track(input logic [7:0] b, input bit raise_phase, input logic [2:0] pv);
    int td = -1;
    for (int k = 0; k < 60; k++) begin
      @(negedge clk_i);
      if (raise_phase) begin
        phase_val_i = pv;
        phase_req_i = 1'b1;
      end
      if (phase_o != cur) chk(0, "R9", "phase moved during send", int'(phase_o), int'(cur));
      if (done_o) begin td = cyc; break; end
    end
    chk(td >= 0, "R7", "send completed", td, 0);
    chk(!pio_en_o, "R7", "enable off at done", int'(pio_en_o), 0);
    chk(td == rdy2_cyc + 1, "R7", "done after second ready", td, rdy2_cyc + 1);
    chk(wr_cnt == 1, "R6", "write strobes", wr_cnt, 1);
    chk(cap == b, "R6", "byte written", int'(cap), int'(b));
    if (!raise_phase) begin
      @(negedge clk_i);
      chk(!done_o && !busy_o, "R5", "idle after send", int'({done_o, busy_o}), 0);
    end
  endtask

  task automatic do_send(input logic [7:0] b);
    send_byte_i = b;
    send_req_i = 1'b1;
    wait_busy();
    send_req_i = 1'b0;
    chk(pio_en_o, "R6", "enable raised", int'(pio_en_o), 1);
    send_track(b, 1'b0, 3'b000);
  endtask

  task automatic summary();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
  endtask

  initial begin
    repeat (150000) @(posedge clk_i);
    errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
    summary();
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk_i);
    chk(phase_o == 3'b000 && !busy_o && !done_o && !pio_en_o && !pio_wr_o,
        "R1", "reset outputs", int'({phase_o, busy_o, done_o, pio_en_o, pio_wr_o}), 0);
    rst_ni = 1'b1;
    repeat (2) @(negedge clk_i);
    chk(phase_o == 3'b000 && !busy_o && !pio_en_o, "R1", "idle after reset",
        int'({phase_o, busy_o, pio_en_o}), 0);

    // directed corners
    do_phase(3'b001, 0);   // 0->1 reversal
    do_phase(3'b000, 2);   // 1->0
    do_phase(3'b000, 0);   // unchanged value
    do_phase(3'b111, 3);   // reversal with ACK held
    do_phase(3'b110, 0);
    do_send(8'hA5);
    do_send(8'h00);

    // R8: both requests in one idle cycle
    begin
      int c_rel;
      ack_i = 1'b0;
      phase_val_i = 3'b011;
      send_byte_i = 8'h3C;
      phase_req_i = 1'b1;
      send_req_i = 1'b1;
      wait_busy();
      phase_req_i = 1'b0;
      chk(!pio_en_o, "R8", "phase served first", int'(pio_en_o), 0);
      c_rel = cyc;
      phase_track(3'b011, c_rel, 1'b1);
      do @(negedge clk_i); while (!pio_en_o && cyc < c_rel + 100);
      send_req_i = 1'b0;
      chk(pio_en_o, "R8", "send served after phase", int'(pio_en_o), 1);
      send_track(8'h3C, 1'b0, 3'b000);
    end

    // R9: phase request raised during a send
    begin
      int c_rel;
      send_byte_i = 8'h5A;
      send_req_i = 1'b1;
      wait_busy();
      send_req_i = 1'b0;
      send_track(8'h5A, 1'b1, 3'b100);
      wait_busy();
      phase_req_i = 1'b0;
      c_rel = cyc;
      phase_track(3'b100, c_rel, 1'b0);
    end

    // R9: send request raised during a phase change
    begin
      int c_rel;
      phase_val_i = 3'b101;
      phase_req_i = 1'b1;
      wait_busy();
      phase_req_i = 1'b0;
      send_byte_i = 8'hC3;
      send_req_i = 1'b1;
      c_rel = cyc;
      phase_track(3'b101, c_rel, 1'b1);
      do @(negedge clk_i); while (!pio_en_o && cyc < c_rel + 100);
      send_req_i = 1'b0;
      send_track(8'hC3, 1'b0, 3'b000);
    end

    // random mix
    for (int i = 0; i < 60; i++) begin
      if ($urandom_range(0, 2) != 0)
        do_phase(3'($urandom_range(0, 7)), int'($urandom_range(0, 4)));
      else
        do_send(8'($urandom_range(0, 255)));
    end

    summary();
    $finish;
  end
endmodule